// File: doc/BRIEF.md
# Pseudo-Static RAM Refresh Sequencer

This block is the refresh control of a pseudo-static RAM, built as synchronous logic on a fast system clock. It watches the active-low chip select and the shared active-low output-enable/refresh pin. It tells three kinds of refresh apart and sends a one-cycle refresh strobe with a row address toward the array.

The three kinds are as follows. A chip-select cycle with neither output nor write enabled refreshes the row that the host puts on the row part of the address. While the chip is deselected, a short low pulse on the refresh pin refreshes the row held in an internal counter, which then advances. If the refresh pin is held low long enough, the block enters self-refresh. There it clears the counter and strobes rows from its own timer until the pin is released. A recovery interval must follow, with both pins high, before normal operation resumes. A second output flags any access that starts during recovery.

All time limits are clock-cycle counts given by parameters. The self-refresh period is chosen so that every row is strobed within the retention window.

Top module: `psr_refresh_seq`

## Requirements
- R1: After reset, mode_o is 0 (idle), strobe_o is 0, row_o is 0, early_o is 0 and the internal row counter is 0.
- R2: In idle mode, a clock sample where ce_n_i has gone from 1 to 0 while oe_rf_n_i is 1 and we_n_i is 1 gives strobe_o high for exactly the next cycle, with row_o equal to row_addr_i. The internal row counter does not move. If we_n_i is 0 on that sample, no strobe is given.
- R3: With ce_n_i high, a low pulse on oe_rf_n_i of L samples, where MIN_PULSE_CYC <= L < AUTO_MAX_CYC, gives one strobe in the cycle after the first high sample. That strobe carries the counter's row, and the counter then advances by one. mode_o reads 1 while the pulse is low.
- R4: A deselected low pulse shorter than MIN_PULSE_CYC samples gives no strobe and leaves the counter unchanged.
- R5: When oe_rf_n_i stays low with ce_n_i high for AUTO_MAX_CYC samples, mode_o becomes 2 (self-refresh) and the counter is cleared to 0. After AUTO_MAX_CYC-1 samples, mode_o is still 1.
- R6: In self-refresh, a strobe comes every SELF_PERIOD_CYC cycles after entry, on consecutive counter rows starting at 0.
- R7: The counter wraps from 2^ROW_BITS-1 to 0.
- R8: Leaving self-refresh (oe_rf_n_i high or ce_n_i low) gives mode_o 3 (recovery) with no strobe. Mode 0 returns after RECOV_CYC consecutive samples with both pins high.
- R9: A sample in recovery with ce_n_i or oe_rf_n_i low raises early_o for the next cycle, gives no strobe, and restarts the recovery count.
- R10: If ce_n_i falls while a deselected refresh pulse is still low, the pulse is dropped with no strobe and the counter is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n_i | input | 1 | Chip select, active low |
| oe_rf_n_i | input | 1 | Shared output-enable / refresh request, active low |
| we_n_i | input | 1 | Write enable, active low |
| row_addr_i | input | ROW_BITS | Row part of the host address |
| strobe_o | output | 1 | One-cycle refresh strobe toward the array |
| row_o | output | ROW_BITS | Row refreshed by the current strobe |
| mode_o | output | 2 | 0 idle, 1 deselected pulse pending, 2 self-refresh, 3 recovery |
| early_o | output | 1 | One-cycle flag: access seen during recovery |

## Verification
A wrong counter value shows on row_o at the next counter-driven strobe, so every auto-refresh pulse checks the state left by all earlier events. A miscounted pulse length shows up one sample early or late at the auto/self boundary, as mode_o reading 2 where 1 is expected. A wrong self timer shows as a strobe one or more cycles off its expected slot. A stuck recovery count shows as mode_o failing to return to 0 on the expected cycle. An addressed refresh that wrongly advanced the counter is exposed by the row of the next auto-refresh.

// File: rtl/psr_pkg.sv
package psr_pkg;

  typedef enum logic [1:0] {
    MODE_IDLE  = 2'd0,
    MODE_AUTO  = 2'd1,
    MODE_SELF  = 2'd2,
    MODE_RECOV = 2'd3
  } psr_mode_e;

  // A pulse of len samples is long enough to count as a refresh request.
  function automatic logic pulse_valid(input int unsigned len, input int unsigned min_len);
    return len >= min_len;
  endfunction

endpackage

// File: rtl/psr_self_timer.sv
module psr_self_timer #(
  parameter int unsigned PERIOD_CYC = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int unsigned CW = $clog2(PERIOD_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(PERIOD_CYC - 1);
  localparam logic [CW-1:0] STEP = CW'(1);

  logic [CW-1:0] cnt;

  assign tick = run && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt <= '0;
    else if (!run)    cnt <= '0;
    else if (tick)    cnt <= '0;
    else              cnt <= cnt + STEP;
  end
endmodule

// File: rtl/psr_row_ctr.sv
module psr_row_ctr #(
  parameter int unsigned ROW_BITS = 11
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clr,
  input  logic                adv,
  output logic [ROW_BITS-1:0] row
);
  localparam logic [ROW_BITS-1:0] ONE = ROW_BITS'(1);

  // Natural wrap at the top of the row space.
  function automatic logic [ROW_BITS-1:0] row_after(input logic [ROW_BITS-1:0] r);
    return r + ONE;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     row <= '0;
    else if (clr)   row <= '0;
    else if (adv)   row <= row_after(row);
  end
endmodule

// File: rtl/psr_mode_fsm.sv
module psr_mode_fsm
  import psr_pkg::*;
#(
  parameter int unsigned MIN_PULSE_CYC = 4,
  parameter int unsigned AUTO_MAX_CYC  = 40,
  parameter int unsigned RECOV_CYC     = 12
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      ce_n,
  input  logic      rf_n,
  input  logic      self_tick,
  output psr_mode_e mode,
  output logic      auto_fire,
  output logic      enter_self,
  output logic      self_fire,
  output logic      leave_self,
  output logic      early_hit
);
  localparam int unsigned LW = $clog2(AUTO_MAX_CYC + 1);
  localparam int unsigned RW = $clog2(RECOV_CYC + 1);
  localparam logic [LW-1:0] LAST_LOW = LW'(AUTO_MAX_CYC - 1);
  localparam logic [LW-1:0] LOW_STEP = LW'(1);
  localparam logic [RW-1:0] LAST_REC = RW'(RECOV_CYC - 1);
  localparam logic [RW-1:0] REC_STEP = RW'(1);

  logic [LW-1:0] low_len;
  logic [RW-1:0] rec_len;
  logic          desel_low;
  logic          both_high;
  logic          rec_done;

  always_comb begin
    desel_low  = ce_n && !rf_n;
    both_high  = ce_n && rf_n;
    auto_fire  = (mode == MODE_AUTO) && both_high &&
                 pulse_valid(int'(low_len), MIN_PULSE_CYC);
    enter_self = (mode == MODE_AUTO) && desel_low && (low_len == LAST_LOW);
    leave_self = (mode == MODE_SELF) && !desel_low;
    self_fire  = (mode == MODE_SELF) && desel_low && self_tick;
    early_hit  = (mode == MODE_RECOV) && !both_high;
    rec_done   = (mode == MODE_RECOV) && both_high && (rec_len == LAST_REC);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode    <= MODE_IDLE;
      low_len <= '0;
      rec_len <= '0;
    end else begin
      unique case (mode)
        MODE_IDLE: if (desel_low) begin
          mode    <= MODE_AUTO;
          low_len <= LOW_STEP;
        end
        MODE_AUTO: begin
          if (enter_self)     mode    <= MODE_SELF;
          else if (desel_low) low_len <= low_len + LOW_STEP;
          else                mode    <= MODE_IDLE;
        end
        MODE_SELF: if (leave_self) begin
          mode    <= MODE_RECOV;
          rec_len <= '0;
        end
        MODE_RECOV: begin
          if (early_hit)     rec_len <= '0;
          else if (rec_done) mode    <= MODE_IDLE;
          else               rec_len <= rec_len + REC_STEP;
        end
        default: mode <= MODE_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/psr_refresh_seq.sv
module psr_refresh_seq
  import psr_pkg::*;
#(
  parameter int unsigned ROW_BITS        = 11,
  parameter int unsigned MIN_PULSE_CYC   = 4,
  parameter int unsigned AUTO_MAX_CYC    = 40,
  parameter int unsigned SELF_PERIOD_CYC = 16,
  parameter int unsigned RECOV_CYC       = 12
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ce_n_i,
  input  logic                oe_rf_n_i,
  input  logic                we_n_i,
  input  logic [ROW_BITS-1:0] row_addr_i,
  output logic                strobe_o,
  output logic [ROW_BITS-1:0] row_o,
  output logic [1:0]          mode_o,
  output logic                early_o
);
  psr_mode_e           mode;
  logic                ce_q;
  logic                self_run;
  logic                self_tick;
  logic                auto_fire;
  logic                enter_self;
  logic                self_fire;
  logic                leave_self;
  logic                early_hit;
  logic                ext_fire;
  logic [ROW_BITS-1:0] row_cnt;

  psr_mode_fsm #(
    .MIN_PULSE_CYC(MIN_PULSE_CYC),
    .AUTO_MAX_CYC (AUTO_MAX_CYC),
    .RECOV_CYC    (RECOV_CYC)
  ) fsm_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .ce_n      (ce_n_i),
    .rf_n      (oe_rf_n_i),
    .self_tick (self_tick),
    .mode      (mode),
    .auto_fire (auto_fire),
    .enter_self(enter_self),
    .self_fire (self_fire),
    .leave_self(leave_self),
    .early_hit (early_hit)
  );

  assign self_run = (mode == MODE_SELF) && ce_n_i && !oe_rf_n_i;

  psr_self_timer #(.PERIOD_CYC(SELF_PERIOD_CYC)) tmr_i (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (self_run),
    .tick (self_tick)
  );

  psr_row_ctr #(.ROW_BITS(ROW_BITS)) ctr_i (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (enter_self),
    .adv  (auto_fire || self_fire),
    .row  (row_cnt)
  );

  // Addressed refresh: chip select falling with output and write disabled.
  assign ext_fire = (mode == MODE_IDLE) && ce_q && !ce_n_i && oe_rf_n_i && we_n_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ce_q     <= 1'b1;
      strobe_o <= 1'b0;
      row_o    <= '0;
      early_o  <= 1'b0;
    end else begin
      ce_q     <= ce_n_i;
      strobe_o <= ext_fire || auto_fire || self_fire;
      early_o  <= early_hit;
      if (ext_fire)                    row_o <= row_addr_i;
      else if (auto_fire || self_fire) row_o <= row_cnt;
    end
  end

  assign mode_o = mode;
endmodule

// File: rtl/psr_refresh_chk.sv
module psr_refresh_chk #(
  parameter int unsigned ROW_BITS = 11
) (
  input logic                clk,
  input logic                rst_n,
  input logic                ce_n_i,
  input logic                oe_rf_n_i,
  input logic                strobe_o,
  input logic [ROW_BITS-1:0] row_o,
  input logic [1:0]          mode_o,
  input logic                early_o,
  input logic [ROW_BITS-1:0] row_cnt,
  input logic                auto_fire,
  input logic                self_fire,
  input logic                ext_fire,
  input logic                enter_self,
  input logic                leave_self
);
  a_r3_auto_row: assert property (@(posedge clk) disable iff (!rst_n)
    auto_fire |=> strobe_o && (row_o == $past(row_cnt)));

  a_r3_auto_adv: assert property (@(posedge clk) disable iff (!rst_n)
    auto_fire |=> row_cnt == ROW_BITS'($past(row_cnt) + 1'b1));

  a_r2_ext_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ext_fire |=> strobe_o && $stable(row_cnt));

  a_r5_self_clear: assert property (@(posedge clk) disable iff (!rst_n)
    enter_self |=> (row_cnt == '0) && (mode_o == 2'd2));

  a_r6_self_row: assert property (@(posedge clk) disable iff (!rst_n)
    self_fire |=> strobe_o && (row_o == $past(row_cnt)));

  a_r7_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    ((auto_fire || self_fire) && (row_cnt == '1)) |=> (row_cnt == '0));

  a_r8_leave: assert property (@(posedge clk) disable iff (!rst_n)
    leave_self |=> (mode_o == 2'd3) && !strobe_o);

  a_r9_early: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode_o == 2'd3) && !(ce_n_i && oe_rf_n_i)) |=> early_o && (mode_o == 2'd3) && !strobe_o);
endmodule

bind psr_refresh_seq psr_refresh_chk #(.ROW_BITS(ROW_BITS)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .ce_n_i    (ce_n_i),
  .oe_rf_n_i (oe_rf_n_i),
  .strobe_o  (strobe_o),
  .row_o     (row_o),
  .mode_o    (mode_o),
  .early_o   (early_o),
  .row_cnt   (row_cnt),
  .auto_fire (auto_fire),
  .self_fire (self_fire),
  .ext_fire  (ext_fire),
  .enter_self(enter_self),
  .leave_self(leave_self)
);

// File: tb/psr_refresh_seq_tb.sv
module psr_refresh_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int ROW_BITS   = 11;
  localparam int MIN_P      = 4;
  localparam int AUTO_MAX   = 40;
  localparam int SELF_P     = 16;
  localparam int RECOV      = 12;
  localparam int ROWS       = 1 << ROW_BITS;

  logic clk = 1'b0;
  logic rst_n, ce_n, rf_n, we_n;
  logic [ROW_BITS-1:0] raddr;
  logic strobe;
  logic [ROW_BITS-1:0] row;
  logic [1:0] mode;
  logic early;

  int n_vec = 0;
  int n_bad = 0;
  int exp_row = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  psr_refresh_seq #(
    .ROW_BITS(ROW_BITS), .MIN_PULSE_CYC(MIN_P), .AUTO_MAX_CYC(AUTO_MAX),
    .SELF_PERIOD_CYC(SELF_P), .RECOV_CYC(RECOV)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .ce_n_i(ce_n), .oe_rf_n_i(rf_n), .we_n_i(we_n),
    .row_addr_i(raddr), .strobe_o(strobe), .row_o(row), .mode_o(mode), .early_o(early)
  );

  function automatic int next_row(input int r);
    return (r + 1) % ROWS;
  endfunction

  function automatic bit is_refresh_len(input int len);
    return (len >= MIN_P) && (len < AUTO_MAX);
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
  endtask

  // Deselected low pulse of len samples (len < AUTO_MAX).
  task automatic auto_pulse(input int len, input string req);
    @(negedge clk); rf_n = 1'b0;
    @(negedge clk); chk({req, " mode pending"}, mode, 1);
    repeat (len - 1) @(negedge clk);
    rf_n = 1'b1;
    @(negedge clk);
    if (is_refresh_len(len)) begin
      chk({req, " strobe"}, strobe, 1);
      chk({req, " row"}, row, exp_row);
      exp_row = next_row(exp_row);
    end else begin
      chk({req, " no strobe"}, strobe, 0);
    end
    @(negedge clk); chk({req, " single strobe"}, strobe, 0);
  endtask

  task automatic ext_ref(input int a, input bit we);
    @(negedge clk); ce_n = 1'b0; we_n = we; raddr = ROW_BITS'(a);
    @(negedge clk);
    chk("R2 ext strobe", strobe, int'(we));
    if (we) chk("R2 ext row", row, a);
    @(negedge clk); chk("R2 ext single", strobe, 0);
    ce_n = 1'b1; we_n = 1'b1;
  endtask

  task automatic enter_self_chk();
    @(negedge clk); rf_n = 1'b0;
    repeat (AUTO_MAX - 1) @(negedge clk);
    chk("R5 still pending", mode, 1);
    @(negedge clk);
    chk("R5 self mode", mode, 2);
    exp_row = 0;
  endtask

  task automatic self_strobes(input int n);
    for (int k = 0; k < n; k++) begin
      repeat (SELF_P - 1) @(negedge clk);
      chk("R6 no strobe between", strobe, 0);
      @(negedge clk);
      chk("R6 self strobe", strobe, 1);
      chk("R6 self row", row, exp_row);
      exp_row = next_row(exp_row);
    end
  endtask

  initial begin
    rst_n = 1'b0; ce_n = 1'b1; rf_n = 1'b1; we_n = 1'b1; raddr = '0;
    void'($urandom(32'h1f2e3d4c));
    repeat (3) @(negedge clk);
    chk("R1 mode", mode, 0);
    chk("R1 strobe", strobe, 0);
    chk("R1 row", row, 0);
    chk("R1 early", early, 0);
    rst_n = 1'b1;

    auto_pulse(MIN_P, "R3 min pulse");          // row 0 and R1 counter start
    auto_pulse(MIN_P - 1, "R4 short");
    auto_pulse(1, "R4 one sample");
    auto_pulse(AUTO_MAX - 1, "R3 longest auto"); // row 1: counter untouched by R4

    ext_ref(ROWS - 1, 1'b1);
    ext_ref(5, 1'b0);
    auto_pulse(MIN_P, "R2 counter held");

    // R10: chip select falls during a pending pulse
    @(negedge clk); rf_n = 1'b0;
    repeat (3) @(negedge clk);
    ce_n = 1'b0;
    @(negedge clk); chk("R10 no strobe", strobe, 0); chk("R10 mode", mode, 0);
    rf_n = 1'b1;
    @(negedge clk); ce_n = 1'b1;
    @(negedge clk); chk("R10 no late strobe", strobe, 0);
    auto_pulse(MIN_P + 1, "R10 counter held");

    for (int i = 0; i < 300; i++) begin
      if ($urandom_range(0, 1) == 0) auto_pulse(int'($urandom_range(1, AUTO_MAX - 1)), "R3 rand");
      else ext_ref(int'($urandom_range(0, ROWS - 1)), 1'($urandom_range(0, 1)));
    end

    // R7: run the counter across the wrap
    while (exp_row != ROWS - 1) auto_pulse(MIN_P, "R3 fill");
    auto_pulse(MIN_P, "R7 top row");
    chk("R7 wrap expected", exp_row, 0);
    auto_pulse(MIN_P, "R7 wrapped row");

    // Self-refresh, then exit by releasing the refresh pin
    enter_self_chk();
    self_strobes(4);
    rf_n = 1'b1;
    @(negedge clk); chk("R8 recovery", mode, 3); chk("R8 no strobe", strobe, 0);
    ce_n = 1'b0;
    @(negedge clk); chk("R9 early", early, 1); chk("R9 no strobe", strobe, 0);
    chk("R9 still recovery", mode, 3);
    ce_n = 1'b1;
    @(negedge clk); chk("R9 early single", early, 0);
    repeat (RECOV - 2) @(negedge clk);
    chk("R8 recovery held", mode, 3);
    @(negedge clk); chk("R8 idle again", mode, 0);

    // Second session: counter restarts; exit by chip select
    auto_pulse(MIN_P, "R3 before self");
    enter_self_chk();
    self_strobes(2);
    ce_n = 1'b0; rf_n = 1'b1;
    @(negedge clk); chk("R8 exit by select", mode, 3); chk("R8 no early on exit", early, 0);
    ce_n = 1'b1;
    repeat (RECOV - 1) @(negedge clk);
    chk("R8 recovery held 2", mode, 3);
    chk("R9 no early", early, 0);
    @(negedge clk); chk("R8 idle 2", mode, 0);
    auto_pulse(MIN_P, "R6 counter continues");

    done = 1;
    report();
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_vec++; n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      report();
      $finish;
    end
  end
endmodule